// File: doc/BRIEF.md
# Three-Channel Edge-Skew Detector

This block compares the rising edges of three digitized channel signals, called red, green and blue, and reports which channel of each pairing rose first and by how many clock cycles. Each of three detectors watches one fixed pairing. The pairings go round the channels: red against green, green against blue, and blue against red. A detector drives its "up" strobe while its first signal leads and its "down" strobe while its second signal leads. The strobe width in clock cycles equals the separation between the two edges.

For every channel there is a raw input signal and a delayed output signal. In normal operation the detectors look at the three delayed outputs. When the test-mode flag is set, the red and blue detectors instead compare their own channel's input against that channel's output. This measures the delay that the channel inserts.

A measurement is valid only while both compared signals are high together. As soon as both are low, a detector drops any half-finished measurement. Each detector also feeds a signed 16-bit accumulator. The accumulator counts up for every up cycle and down for every down cycle, so software can average the skew over many edges. A synchronous clear input empties all three accumulators.

Top module: `skew_detect`

## Requirements
- R1: After reset, every upPulse and dnPulse bit is 0 and every accumulator field of skewAcc reads 0.
- R2: Detector 0 (red) compares A=chOut[0] with B=chOut[1], detector 1 (green) compares A=chOut[1] with B=chOut[2], and detector 2 (blue) compares A=chOut[2] with B=chOut[0], while testMode is 0.
- R3: When A's rising edge is sampled k cycles before B's rising edge, the detector's upPulse bit is high for exactly k cycles, starting in the cycle after A's edge is sampled, and its dnPulse bit stays low.
- R4: When B's rising edge is sampled k cycles before A's rising edge, dnPulse is high for exactly k cycles and upPulse stays low.
- R5: When A and B rise in the same sampled cycle, neither strobe of that detector is asserted.
- R6: A sampled cycle in which both A and B are low clears the detector, so both strobes are low in the next cycle. If the two pulses never overlap, each edge therefore yields a strobe that lasts until both signals are low.
- R7: A detector never asserts upPulse and dnPulse in the same cycle.
- R8: While testMode is 1, detector 0 compares A=chIn[0] with B=chOut[0], detector 2 compares A=chIn[2] with B=chOut[2], and detector 1 keeps its normal pairing.
- R9: While testMode is 0, chIn has no effect on any output.
- R10: Field d of skewAcc is bits [16*d+15:16*d]. It holds a two's-complement sum that gains 1 for each cycle the detector's upPulse is high and loses 1 for each cycle its dnPulse is high. It is held otherwise.
- R11: accClr high at a clock edge sets all three accumulator fields to 0 at that edge, and it overrides counting.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; all sampling and strobe timing is in its cycles |
| rstN | input | 1 | Asynchronous active-low reset |
| testMode | input | 1 | 1 retargets the red and blue detectors onto their own channel's input-to-output path |
| accClr | input | 1 | Synchronous clear of all accumulators |
| chIn | input | 3 | Digitized channel inputs, bit 0 red, bit 1 green, bit 2 blue |
| chOut | input | 3 | Digitized delayed channel outputs, same bit order |
| upPulse | output | 3 | Per-detector strobe: A leads B |
| dnPulse | output | 3 | Per-detector strobe: B leads A |
| skewAcc | output | 48 | Three signed 16-bit accumulators, field d for detector d |

## Verification
A stuck or missed edge latch shows up at the ports as a strobe that is too long, too short or missing. The strobe appears one cycle after the faulty edge and lasts until both compared signals go low, so the error is visible in the width measured over a single edge pair. Routing faults in the test-mode multiplexer, and edge-ordering faults, change which strobe appears and how wide it is for carefully staggered edges. Accumulator faults persist in skewAcc until the next clear. They are therefore checked once a pattern has settled, against the sum of the up and down widths that were measured.

// File: rtl/skew_pkg.sv
package skew_pkg;
  localparam int NUM_DET = 3;
  localparam int ACC_W = 16;
  // detectors that may be retargeted onto their own channel path in test mode
  localparam logic [NUM_DET-1:0] TEST_MASK = 3'b101;

  typedef struct packed {
    logic up;
    logic dn;
  } skewStrobe_t;
endpackage

// File: rtl/skew_route.sv
module skew_route
  import skew_pkg::*;
(
  input  logic               testMode,
  input  logic [NUM_DET-1:0] chIn,
  input  logic [NUM_DET-1:0] chOut,
  output logic [NUM_DET-1:0] sigA,
  output logic [NUM_DET-1:0] sigB
);
  for (genvar d = 0; d < NUM_DET; d++) begin : g_pair
    localparam int NEXT = (d + 1) % NUM_DET;
    if (TEST_MASK[d]) begin : g_test
      assign sigA[d] = testMode ? chIn[d]  : chOut[d];
      assign sigB[d] = testMode ? chOut[d] : chOut[NEXT];
    end else begin : g_fixed
      assign sigA[d] = chOut[d];
      assign sigB[d] = chOut[NEXT];
    end
  end
endmodule

// File: rtl/skew_latch.sv
module skew_latch
  import skew_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        sigA,
  input  logic        sigB,
  output skewStrobe_t strobe
);
  logic aPrev, bPrev, aSet, bSet;
  logic aRise, bRise, release_;

  assign aRise    = sigA & ~aPrev;
  assign bRise    = sigB & ~bPrev;
  assign release_ = (aSet & bSet) | (~sigA & ~sigB);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      aPrev <= 1'b0;
      bPrev <= 1'b0;
      aSet  <= 1'b0;
      bSet  <= 1'b0;
    end else begin
      aPrev <= sigA;
      bPrev <= sigB;
      if (release_) begin
        aSet <= 1'b0;
        bSet <= 1'b0;
      end else begin
        aSet <= aSet | aRise;
        bSet <= bSet | bRise;
      end
    end
  end

  assign strobe.up = aSet & ~bSet;
  assign strobe.dn = bSet & ~aSet;

  // R7: strobes are mutually exclusive
  a_r7_exclusive: assert property (@(posedge clk) disable iff (!rstN)
    !(strobe.up && strobe.dn));
  // R6: both inputs low releases the detector
  a_r6_release: assert property (@(posedge clk) disable iff (!rstN)
    (!sigA && !sigB) |=> (!strobe.up && !strobe.dn));
  // R3: an up strobe only starts after A was seen high
  a_r3_up_start: assert property (@(posedge clk) disable iff (!rstN)
    $rose(strobe.up) |-> $past(sigA));
  // R4: a down strobe only starts after B was seen high
  a_r4_dn_start: assert property (@(posedge clk) disable iff (!rstN)
    $rose(strobe.dn) |-> $past(sigB));
endmodule

// File: rtl/skew_accum.sv
module skew_accum
  import skew_pkg::*;
#(
  parameter int W = ACC_W
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                accClr,
  input  skewStrobe_t         strobe,
  output logic signed [W-1:0] acc
);
  localparam logic signed [W-1:0] STEP_UP = W'(1);
  localparam logic signed [W-1:0] STEP_DN = -STEP_UP;

  logic signed [W-1:0] step;

  always_comb begin
    step = '0;
    if (strobe.up)      step = STEP_UP;
    else if (strobe.dn) step = STEP_DN;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)       acc <= '0;
    else if (accClr) acc <= '0;
    else             acc <= acc + step;
  end

  // R11: clear wins over counting
  a_r11_clear: assert property (@(posedge clk) disable iff (!rstN)
    accClr |=> (acc == '0));
  // R10: no strobe, no change
  a_r10_hold: assert property (@(posedge clk) disable iff (!rstN)
    (!accClr && !strobe.up && !strobe.dn) |=> $stable(acc));
endmodule

// File: rtl/skew_detect.sv
module skew_detect
  import skew_pkg::*;
#(
  parameter int W = ACC_W
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 testMode,
  input  logic                 accClr,
  input  logic [NUM_DET-1:0]   chIn,
  input  logic [NUM_DET-1:0]   chOut,
  output logic [NUM_DET-1:0]   upPulse,
  output logic [NUM_DET-1:0]   dnPulse,
  output logic [NUM_DET*W-1:0] skewAcc
);
  logic [NUM_DET-1:0] sigA, sigB;
  skewStrobe_t        strobe [NUM_DET];

  skew_route i_route (
    .testMode(testMode),
    .chIn    (chIn),
    .chOut   (chOut),
    .sigA    (sigA),
    .sigB    (sigB)
  );

  for (genvar d = 0; d < NUM_DET; d++) begin : g_det
    logic signed [W-1:0] accVal;

    skew_latch i_latch (
      .clk   (clk),
      .rstN  (rstN),
      .sigA  (sigA[d]),
      .sigB  (sigB[d]),
      .strobe(strobe[d])
    );

    skew_accum #(.W(W)) i_accum (
      .clk   (clk),
      .rstN  (rstN),
      .accClr(accClr),
      .strobe(strobe[d]),
      .acc   (accVal)
    );

    assign upPulse[d]          = strobe[d].up;
    assign dnPulse[d]          = strobe[d].dn;
    assign skewAcc[d*W +: W]   = accVal;
  end
endmodule

// File: tb/test_skew_detect.sv
module test_skew_detect;
  localparam int W = 16;
  localparam int NEVER = 999;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic testMode = 1'b0;
  logic accClr = 1'b0;
  logic [2:0] chIn = '0;
  logic [2:0] chOut = '0;
  logic [2:0] upPulse, dnPulse;
  logic [3*W-1:0] skewAcc;

  skew_detect i_skew_detect (
    .clk(clk), .rstN(rstN), .testMode(testMode), .accClr(accClr),
    .chIn(chIn), .chOut(chOut), .upPulse(upPulse), .dnPulse(dnPulse),
    .skewAcc(skewAcc)
  );

  always #10 clk = ~clk;

  typedef struct {
    int    det;
    int    up;
    int    dn;
    int    acc;
    string req;
  } expItem_t;

  expItem_t expQ[$];
  int checks = 0;
  int errors = 0;
  int upCnt[3] = '{0, 0, 0};
  int dnCnt[3] = '{0, 0, 0};
  bit finished = 0;

  int rIn[3], fIn[3], rOut[3], fOut[3];

  // monitor: counts strobe cycles and scores queued expectations
  always @(negedge clk) begin
    #5;
    for (int d = 0; d < 3; d++) begin
      if (upPulse[d]) upCnt[d]++;
      if (dnPulse[d]) dnCnt[d]++;
      if (upPulse[d] && dnPulse[d]) begin
        errors++;
        $display("FAIL R7 det%0d: up=1 dn=1 expected not both", d);
      end
    end
    while (expQ.size() > 0) begin
      expItem_t e;
      int accGot;
      e = expQ.pop_front();
      accGot = int'($signed(skewAcc[e.det*W +: W]));
      checks += 3;
      if (upCnt[e.det] != e.up) begin
        errors++;
        $display("FAIL %s det%0d up cycles: got %0d expected %0d", e.req, e.det, upCnt[e.det], e.up);
      end
      if (dnCnt[e.det] != e.dn) begin
        errors++;
        $display("FAIL %s det%0d dn cycles: got %0d expected %0d", e.req, e.det, dnCnt[e.det], e.dn);
      end
      if (accGot != e.acc) begin
        errors++;
        $display("FAIL %s R10 det%0d acc: got %0d expected %0d", e.req, e.det, accGot, e.acc);
      end
      upCnt[e.det] = 0;
      dnCnt[e.det] = 0;
    end
  end

  task automatic push(input int d, input int up, input int dn, input int acc, input string req);
    expItem_t e;
    e.det = d; e.up = up; e.dn = dn; e.acc = acc; e.req = req;
    expQ.push_back(e);
  endtask

  task automatic waitDrain();
    while (expQ.size() > 0) @(negedge clk);
    @(negedge clk);
  endtask

  // driver: plays one edge pattern, then idles with all signals low
  task automatic runPat(input bit tm, input bit clr, input int len);
    @(negedge clk);
    testMode = tm;
    accClr = clr;
    @(negedge clk);
    accClr = 1'b0;
    for (int t = 0; t < len; t++) begin
      @(negedge clk);
      for (int c = 0; c < 3; c++) begin
        chIn[c]  = (t >= rIn[c])  && (t < fIn[c]);
        chOut[c] = (t >= rOut[c]) && (t < fOut[c]);
      end
    end
    @(negedge clk);
    chIn = '0;
    chOut = '0;
    repeat (3) @(negedge clk);
  endtask

  task automatic setPat(input int ri0, ri1, ri2, fi, ro0, ro1, ro2, fo);
    rIn  = '{ri0, ri1, ri2};
    fIn  = '{fi, fi, fi};
    rOut = '{ro0, ro1, ro2};
    fOut = '{fo, fo, fo};
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    // R1: reset state
    push(0, 0, 0, 0, "R1"); push(1, 0, 0, 0, "R1"); push(2, 0, 0, 0, "R1");
    waitDrain();

    // R2 R3 R4 R9: staggered outputs, inputs toggling but ignored
    setPat(7, 1, 3, 15, 2, 5, 9, 20);
    runPat(1'b0, 1'b1, 24);
    push(0, 3, 0, 3, "R2_R3_R9"); push(1, 4, 0, 4, "R2_R3_R9"); push(2, 0, 7, -7, "R2_R4_R9");
    waitDrain();

    // R4 R5 R11: red late, green and blue together
    setPat(NEVER, NEVER, NEVER, NEVER, 10, 4, 4, 20);
    runPat(1'b0, 1'b1, 24);
    push(0, 0, 6, -6, "R4_R11"); push(1, 0, 0, 0, "R5"); push(2, 6, 0, 6, "R3");
    waitDrain();

    // R6: pulses that never overlap
    rIn = '{NEVER, NEVER, NEVER}; fIn = '{NEVER, NEVER, NEVER};
    rOut = '{2, 8, NEVER}; fOut = '{5, 10, NEVER};
    runPat(1'b0, 1'b1, 14);
    push(0, 3, 2, 1, "R6"); push(1, 2, 0, 2, "R6"); push(2, 0, 3, -3, "R6");
    waitDrain();

    // R8: test mode retargets red and blue onto their own paths
    setPat(1, 2, 3, 20, 6, 10, 4, 20);
    runPat(1'b1, 1'b1, 24);
    push(0, 5, 0, 5, "R8"); push(1, 0, 6, -6, "R8"); push(2, 1, 0, 1, "R8");
    waitDrain();

    // R10: no clear, accumulates on top of previous sums
    setPat(7, 1, 3, 15, 2, 5, 9, 20);
    runPat(1'b0, 1'b0, 24);
    push(0, 3, 0, 8, "R10"); push(1, 4, 0, -2, "R10"); push(2, 0, 7, -6, "R10");
    waitDrain();

    // R11: clear alone
    setPat(NEVER, NEVER, NEVER, NEVER, NEVER, NEVER, NEVER, NEVER);
    runPat(1'b0, 1'b1, 2);
    push(0, 0, 0, 0, "R11"); push(1, 0, 0, 0, "R11"); push(2, 0, 0, 0, "R11");
    waitDrain();

    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #(20 * 200000);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog: run did not complete, expected completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule